// File: doc/BRIEF.md
# Programmable Tag Check Unit

This unit sits beside a pipeline that carries a one-bit taint tag with every register value and memory word. Each cycle it compares the tags of the instruction in the execute stage (its source operands, its result and, for memory accesses, its address and data) and the tag of the target the fetch stage is about to use. It checks them against a 22-bit check policy register that software writes through a simple write port. When a tagged value is used in a way the policy forbids, the unit emits a one-cycle security exception pulse together with a cause code. The cause code is the index of the policy bit that failed.

Each instruction class has its own group of enable bits, and inside each group every operand role has its own bit. Software therefore chooses exactly which uses of tainted data trap and which are allowed. With the policy at zero, the unit never raises an exception.

Top module: `tag_check_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the policy register clears to zero and `sec_exc_o` and `cause_o` are 0 after that edge.
- R2: With the policy register at all zeros, no combination of tags, classes or fetch targets raises `sec_exc_o`.
- R3: A write (`pol_wr_en_i` high at an edge) loads `pol_wr_data_i`. The new value governs checks from the next edge onward. An instruction presented in the same cycle as the write is checked against the old value.
- R4: A violation present at clock edge t sets `sec_exc_o` high for the cycle after edge t only. `cause_o` then carries the failing policy bit index (0..21). When no violation is present at an edge, `sec_exc_o` is 0 after it.
- R5: Policy bit 0 is the execute check. When `fetch_valid_i` and `fetch_tag_i` are both high and bit 0 is set, an exception with cause 0 is raised, whatever the instruction class.
- R6: Classes are encoded as 1 arithmetic, 2 branch, 3 jump, 4 shift and 5 logical. Each of these classes owns a 3-bit field starting at bit 3*class-2 (1, 4, 7, 10, 13). Within a field, bit+0 checks the rs1 tag, bit+1 checks the rs2 tag and bit+2 checks the result tag.
- R7: Class 6 (comparison) owns bits 17:16. Bit 16 checks rs1 and bit 17 checks rs2. The result tag of a comparison is never checked.
- R8: Class 7 (load/store) owns bits 21:18. Bit 18 checks the source-address tag, bit 19 the source-data tag, bit 20 the destination-data tag and bit 21 the destination-address tag.
- R9: Tags trap only through the field of the current class and only when `instr_valid_i` is high. A tagged arithmetic instruction whose arithmetic field is zero raises nothing, even when every other bit is set. Class 0 checks nothing.
- R10: When several checks fail at the same edge, `cause_o` reports the lowest-numbered failing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pol_wr_en_i | input | 1 | Policy register write strobe |
| pol_wr_data_i | input | 22 | New policy value |
| instr_valid_i | input | 1 | Execute-stage instruction is valid |
| instr_class_i | input | 3 | Instruction class code (R6–R9) |
| rs1_tag_i | input | 1 | Tag of first source operand |
| rs2_tag_i | input | 1 | Tag of second source operand |
| rd_tag_i | input | 1 | Tag of the result |
| ls_src_addr_tag_i | input | 1 | Tag of load/store source address |
| ls_src_data_tag_i | input | 1 | Tag of load/store source data |
| ls_dst_data_tag_i | input | 1 | Tag of load/store destination data |
| ls_dst_addr_tag_i | input | 1 | Tag of load/store destination address |
| fetch_valid_i | input | 1 | Fetch stage is issuing a fetch |
| fetch_tag_i | input | 1 | Tag of the fetch target |
| sec_exc_o | output | 1 | Security exception pulse |
| cause_o | output | 5 | Index of the failing policy bit |

## Verification
The bench sets single policy bits and presents each operand role alone. A design with a shifted field layout or swapped roles would report the wrong cause or stay silent. It checks the write-and-use-in-the-same-cycle case, where a design that forwards the incoming policy would trap one cycle early. It also checks the comparison result tag and an arithmetic instruction under a policy that has every other bit set, which catch designs that check roles or classes that are not enabled. With all failures present at once, a priority encoder that favours high bits would report 21 or 18 instead of 0.

// File: rtl/tcu_pkg.sv
// Package: shared layout constants and class codes for the tag check unit.
// Assumes the policy layout is fixed; a neighbour that writes the policy
// decodes fields at these positions.
package tcu_pkg;
    localparam int POLICY_W   = 22;
    localparam int CAUSE_W    = $clog2(POLICY_W);
    localparam int CLASS_W    = 3;
    localparam int EXEC_BIT   = 0;
    localparam int TRIPLE_W   = 3;
    localparam int TRIPLE_CNT = 5;
    localparam int TRIPLE_LO  = 1;
    localparam int CMP_LO     = TRIPLE_LO + TRIPLE_W * TRIPLE_CNT;
    localparam int CMP_W      = 2;
    localparam int LS_LO      = CMP_LO + CMP_W;
    localparam int LS_W       = 4;

    typedef enum logic [CLASS_W-1:0] {
        CLS_NONE  = 3'd0,
        CLS_ARITH = 3'd1,
        CLS_BRAN  = 3'd2,
        CLS_JUMP  = 3'd3,
        CLS_SHIFT = 3'd4,
        CLS_LOGIC = 3'd5,
        CLS_CMP   = 3'd6,
        CLS_LDST  = 3'd7
    } op_class_e;
endpackage

// File: rtl/tcu_policy_reg.sv
// Module: holds the check policy. A write lands at the clock edge and is
// visible from the following edge. Assumes synchronous active-low reset.
module tcu_policy_reg
    import tcu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [POLICY_W-1:0] wr_data_i,
    output logic [POLICY_W-1:0] policy_o
);
    // Purpose: load or clear the policy register.
    always_ff @(posedge clk) begin
        if (!rst_n)       policy_o <= '0;
        else if (wr_en_i) policy_o <= wr_data_i;
    end

    // R3: a write is seen one edge later
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> policy_o == $past(wr_data_i));
    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(policy_o));
endmodule

// File: rtl/tcu_violation_gen.sv
// Module: builds one violation bit per policy bit from the current tags,
// the class of the execute-stage instruction and the fetch target tag.
// Assumes at most one instruction per cycle and tags already aligned.
module tcu_violation_gen
    import tcu_pkg::*;
(
    input  logic [POLICY_W-1:0] policy_i,
    input  logic                instr_valid_i,
    input  logic [CLASS_W-1:0]  instr_class_i,
    input  logic                rs1_tag_i,
    input  logic                rs2_tag_i,
    input  logic                rd_tag_i,
    input  logic [LS_W-1:0]     ls_tags_i,
    input  logic                fetch_valid_i,
    input  logic                fetch_tag_i,
    output logic [POLICY_W-1:0] viol_o
);
    op_class_e cls;
    logic [TRIPLE_W-1:0] role_tags;
    logic [TRIPLE_W-1:0] trip_hit [TRIPLE_CNT];
    logic [CMP_W-1:0]    cmp_hit;
    logic [LS_W-1:0]     ls_hit;
    logic                exec_hit;

    assign cls       = op_class_e'(instr_class_i);
    assign role_tags = {rd_tag_i, rs2_tag_i, rs1_tag_i};

    // One checker per 3-bit class field; class code k+1 owns field k.
    for (genvar k = 0; k < TRIPLE_CNT; k++) begin : g_triple
        localparam int LO = TRIPLE_LO + TRIPLE_W * k;
        logic sel;
        assign sel         = instr_valid_i && (instr_class_i == CLASS_W'(k + 1));
        assign trip_hit[k] = sel ? (role_tags & policy_i[LO +: TRIPLE_W]) : '0;
    end

    // Purpose: comparison checks source operands only.
    always_comb begin
        cmp_hit = '0;
        if (instr_valid_i && cls == CLS_CMP)
            cmp_hit = {rs2_tag_i, rs1_tag_i} & policy_i[CMP_LO +: CMP_W];
    end

    // Purpose: load/store checks its four address/data roles.
    always_comb begin
        ls_hit = '0;
        if (instr_valid_i && cls == CLS_LDST)
            ls_hit = ls_tags_i & policy_i[LS_LO +: LS_W];
    end

    // Purpose: execute check on the fetch target, independent of class.
    always_comb begin
        exec_hit = fetch_valid_i && fetch_tag_i && policy_i[EXEC_BIT];
    end

    // Purpose: gather all hits into the vector indexed by policy bit.
    always_comb begin
        viol_o           = '0;
        viol_o[EXEC_BIT] = exec_hit;
        for (int k = 0; k < TRIPLE_CNT; k++)
            viol_o[TRIPLE_LO + TRIPLE_W * k +: TRIPLE_W] = trip_hit[k];
        viol_o[CMP_LO +: CMP_W] = cmp_hit;
        viol_o[LS_LO +: LS_W]   = ls_hit;
    end

    // R9 / R2: a violation only where the policy enables it
    always_comb begin
        a_r2_enabled_only: assert ((viol_o & ~policy_i) == '0);
    end
endmodule

// File: rtl/tcu_prio_enc.sv
// Module: reports the lowest set bit of a vector and whether any bit is set.
// Assumes a vector width of at least two.
module tcu_prio_enc #(
    parameter int W  = 22,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    logic [W-1:0] below_mask;

    // Purpose: scan from the top down so the lowest set bit is kept last.
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--)
            if (vec_i[i]) idx_o = IW'(i);
        any_o = |vec_i;
    end

    // Purpose: mask of bits below the chosen index, used by the check.
    always_comb begin
        below_mask = (W'(1) << idx_o) - W'(1);
    end

    // R10: chosen bit is set and nothing lower is
    a_r10_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (vec_i[idx_o] && ((vec_i & below_mask) == '0)));
endmodule

// File: rtl/tag_check_unit.sv
// Module: top of the tag check unit. Combines policy register, violation
// builder and priority encoder, and registers the exception and cause.
// Assumes the core handles the trap; this unit only reports it.
module tag_check_unit
    import tcu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pol_wr_en_i,
    input  logic [21:0]         pol_wr_data_i,
    input  logic                instr_valid_i,
    input  logic [2:0]          instr_class_i,
    input  logic                rs1_tag_i,
    input  logic                rs2_tag_i,
    input  logic                rd_tag_i,
    input  logic                ls_src_addr_tag_i,
    input  logic                ls_src_data_tag_i,
    input  logic                ls_dst_data_tag_i,
    input  logic                ls_dst_addr_tag_i,
    input  logic                fetch_valid_i,
    input  logic                fetch_tag_i,
    output logic                sec_exc_o,
    output logic [4:0]          cause_o
);
    logic [POLICY_W-1:0] policy_q;
    logic [POLICY_W-1:0] viol;
    logic                viol_any;
    logic [CAUSE_W-1:0]  viol_idx;

    tcu_policy_reg u_policy (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (pol_wr_en_i),
        .wr_data_i (pol_wr_data_i),
        .policy_o  (policy_q)
    );

    tcu_violation_gen u_viol (
        .policy_i      (policy_q),
        .instr_valid_i (instr_valid_i),
        .instr_class_i (instr_class_i),
        .rs1_tag_i     (rs1_tag_i),
        .rs2_tag_i     (rs2_tag_i),
        .rd_tag_i      (rd_tag_i),
        .ls_tags_i     ({ls_dst_addr_tag_i, ls_dst_data_tag_i,
                         ls_src_data_tag_i, ls_src_addr_tag_i}),
        .fetch_valid_i (fetch_valid_i),
        .fetch_tag_i   (fetch_tag_i),
        .viol_o        (viol)
    );

    tcu_prio_enc #(.W(POLICY_W)) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .vec_i (viol),
        .any_o (viol_any),
        .idx_o (viol_idx)
    );

    // Purpose: register the exception pulse and its cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_exc_o <= 1'b0;
            cause_o   <= '0;
        end else begin
            sec_exc_o <= viol_any;
            cause_o   <= viol_any ? viol_idx : '0;
        end
    end

    // R1: reset clears outputs
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sec_exc_o && cause_o == '0 && policy_q == '0));
    // R2: zero policy never traps
    a_r2_zero_policy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_q == '0) |=> !sec_exc_o);
    // R5: tagged fetch with execute check traps with cause 0
    a_r5_fetch_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && fetch_tag_i && policy_q[EXEC_BIT]) |=> (sec_exc_o && cause_o == '0));
    // R9: nothing valid, nothing reported
    a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid_i && !fetch_valid_i) |=> !sec_exc_o);
    // R4: cause stays inside the policy width
    a_r4_cause_range: assert property (@(posedge clk) disable iff (!rst_n)
        sec_exc_o |-> (cause_o < 5'(POLICY_W)));
endmodule

// File: tb/tag_check_unit_tb_top.sv
module tag_check_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pol_wr_en;
    logic [21:0] pol_wr_data;
    logic        instr_valid;
    logic [2:0]  instr_class;
    logic        rs1_tag, rs2_tag, rd_tag;
    logic        sa_tag, sd_tag, dd_tag, da_tag;
    logic        fetch_valid, fetch_tag;
    logic        sec_exc;
    logic [4:0]  cause;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tag_check_unit dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .pol_wr_en_i       (pol_wr_en),
        .pol_wr_data_i     (pol_wr_data),
        .instr_valid_i     (instr_valid),
        .instr_class_i     (instr_class),
        .rs1_tag_i         (rs1_tag),
        .rs2_tag_i         (rs2_tag),
        .rd_tag_i          (rd_tag),
        .ls_src_addr_tag_i (sa_tag),
        .ls_src_data_tag_i (sd_tag),
        .ls_dst_data_tag_i (dd_tag),
        .ls_dst_addr_tag_i (da_tag),
        .fetch_valid_i     (fetch_valid),
        .fetch_tag_i       (fetch_tag),
        .sec_exc_o         (sec_exc),
        .cause_o           (cause)
    );

    task automatic expect_out(input string req, input bit exp_exc, input int exp_cause);
        checks++;
        if (sec_exc !== exp_exc || (exp_exc && cause !== 5'(exp_cause))) begin
            errors++;
            $display("FAIL %s: exc=%0b cause=%0d expected exc=%0b cause=%0d",
                     req, sec_exc, cause, exp_exc, exp_cause);
        end
    endtask

    task automatic idle_inputs();
        pol_wr_en = 0; pol_wr_data = '0; instr_valid = 0; instr_class = 0;
        rs1_tag = 0; rs2_tag = 0; rd_tag = 0;
        sa_tag = 0; sd_tag = 0; dd_tag = 0; da_tag = 0;
        fetch_valid = 0; fetch_tag = 0;
    endtask

    task automatic write_policy(input logic [21:0] v);
        @(negedge clk);
        idle_inputs();
        pol_wr_en = 1; pol_wr_data = v;
        @(negedge clk);
        pol_wr_en = 0;
    endtask

    // present one instruction at a negedge, sample after the next edge
    task automatic issue(input logic [2:0] cls, input logic [2:0] roles,
                         input logic [3:0] ls, input bit fv, input bit ft,
                         input bit valid, input string req,
                         input bit exp_exc, input int exp_cause);
        @(negedge clk);
        instr_valid = valid; instr_class = cls;
        {rd_tag, rs2_tag, rs1_tag} = roles;
        {da_tag, dd_tag, sd_tag, sa_tag} = ls;
        fetch_valid = fv; fetch_tag = ft;
        @(posedge clk); #1;
        expect_out(req, exp_exc, exp_cause);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1 expect_out("R1", 0, 0);
        @(negedge clk); rst_n = 1;
    endtask

    task automatic t_zero_policy();
        issue(3'd1, 3'b111, 4'hF, 1, 1, 1, "R2 arith", 0, 0);
        issue(3'd7, 3'b111, 4'hF, 1, 1, 1, "R2 ldst", 0, 0);
    endtask

    task automatic t_fetch();
        write_policy(22'h1);
        issue(3'd0, 3'b000, 4'h0, 1, 1, 0, "R5 tagged fetch", 1, 0);
        issue(3'd0, 3'b000, 4'h0, 1, 0, 0, "R5 clean fetch", 0, 0);
    endtask

    task automatic t_triples();
        write_policy(22'h1 << 1);
        issue(3'd1, 3'b001, 4'h0, 0, 0, 1, "R6 arith rs1", 1, 1);
        issue(3'd1, 3'b010, 4'h0, 0, 0, 1, "R6 arith rs2 not enabled", 0, 0);
        write_policy(22'h1 << 2);
        issue(3'd1, 3'b010, 4'h0, 0, 0, 1, "R6 arith rs2", 1, 2);
        write_policy(22'h1 << 3);
        issue(3'd1, 3'b100, 4'h0, 0, 0, 1, "R6 arith result", 1, 3);
        write_policy(22'h1 << 9);
        issue(3'd3, 3'b100, 4'h0, 0, 0, 1, "R6 jump result", 1, 9);
        write_policy(22'h1 << 14);
        issue(3'd5, 3'b010, 4'h0, 0, 0, 1, "R6 logical rs2", 1, 14);
    endtask

    task automatic t_compare();
        write_policy(22'h3 << 16);
        issue(3'd6, 3'b010, 4'h0, 0, 0, 1, "R7 cmp rs2", 1, 17);
        issue(3'd6, 3'b100, 4'h0, 0, 0, 1, "R7 cmp result ignored", 0, 0);
    endtask

    task automatic t_ldst();
        write_policy(22'h1 << 21);
        issue(3'd7, 3'b000, 4'b1000, 0, 0, 1, "R8 dst addr", 1, 21);
        issue(3'd7, 3'b000, 4'b0001, 0, 0, 1, "R8 src addr not enabled", 0, 0);
        write_policy(22'h1 << 18);
        issue(3'd7, 3'b000, 4'b0001, 0, 0, 1, "R8 src addr", 1, 18);
        write_policy(22'h1 << 20);
        issue(3'd7, 3'b000, 4'b0100, 0, 0, 1, "R8 dst data", 1, 20);
    endtask

    task automatic t_ignore();
        write_policy(22'h3FFFFF & ~22'hE);
        issue(3'd1, 3'b111, 4'hF, 0, 0, 1, "R9 arith field clear", 0, 0);
        issue(3'd7, 3'b111, 4'hF, 0, 0, 0, "R9 invalid instr", 0, 0);
        issue(3'd0, 3'b111, 4'hF, 0, 0, 1, "R9 class none", 0, 0);
    endtask

    task automatic t_priority();
        write_policy(22'h3FFFFF);
        issue(3'd7, 3'b000, 4'hF, 0, 0, 1, "R10 ldst all", 1, 18);
        issue(3'd7, 3'b000, 4'hF, 1, 1, 1, "R10 fetch beats ldst", 1, 0);
        issue(3'd4, 3'b110, 4'h0, 0, 0, 1, "R10 shift rs2 before result", 1, 11);
    endtask

    task automatic t_write_timing();
        write_policy(22'h0);
        @(negedge clk);
        pol_wr_en = 1; pol_wr_data = 22'h1 << 1;
        instr_valid = 1; instr_class = 3'd1; rs1_tag = 1;
        @(posedge clk); #1;
        expect_out("R3 old policy used", 0, 0);
        @(negedge clk);
        pol_wr_en = 0;
        @(posedge clk); #1;
        expect_out("R3 new policy used", 1, 1);
        @(negedge clk);
        idle_inputs();
        @(posedge clk); #1;
        expect_out("R4 single pulse", 0, 0);
    endtask

    initial begin
        t_reset();
        t_zero_policy();
        t_fetch();
        t_triples();
        t_compare();
        t_ldst();
        t_ignore();
        t_priority();
        t_write_timing();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule